// File: doc/BRIEF.md
# Edge-Triggered Conversion Queue Sequencer

This block walks a small table of conversion command words and issues one conversion per word to an external converter. An edge on an asynchronous trigger pin starts the walk. A configuration bit picks whether the rising or the falling edge counts. Each word carries a channel number and a pause bit. The sequencer asks the converter to start, and it advances to the next word only when the converter returns its done strobe. The walk stops at an end-of-queue condition and starts again from the first word on the next qualifying edge, with no software action needed in between.

A word that has its pause bit set stops the walk after that word's conversion. The next qualifying edge resumes the walk at the following word. If a qualifying edge arrives while a conversion is in flight, the block sets a sticky overrun flag and the edge has no other effect. Completion, pause and overrun are reported through sticky flags that are cleared by writing a one. Pulling the enable low returns the sequencer to idle with its pointer on the first word. The command table is read through an asynchronous read port that is addressed by the current pointer.

Top module: `trig_queue_seq`

## Requirements
- R1: When `trig_pol`=1 only a rising edge of `trig_in` starts or resumes the queue. When `trig_pol`=0 only a falling edge does. An edge in the other direction starts nothing.
- R2: A started queue issues the words in table order from entry 0. Each word produces one single-cycle `conv_start` pulse with `conv_chan` equal to that word's channel. The next word is issued only after `conv_done`.
- R3: After the queue completes, the next qualifying edge restarts it from entry 0 and needs no other input.
- R4: A word whose channel is all ones (15 at the default width) ends the queue and issues no conversion. The queue also ends after the conversion of the last entry (entry 7 at the default depth). At the end of the queue `cmp_flag` sets and `ccw_ptr` returns to 0.
- R5: A word that has `ccw_pause`=1 and is not the last entry causes a wait after its conversion. During the wait `pause_flag` sets and `ccw_ptr` holds the following entry. The next qualifying edge resumes the queue there. A pause on the last entry counts only as completion.
- R6: A qualifying edge that arrives while `busy`=1 sets `ovr_flag`. It does not change the sequence of conversions.
- R7: Each flag stays set until its bit of `flag_clr` is high. The bits are: bit 0 for completion, bit 1 for pause, bit 2 for overrun. If a flag is set and cleared in the same cycle, it stays set.
- R8: While `enable`=0 the block is idle, `ccw_ptr`=0, and no conversion starts.
- R9: The trigger passes through a two-stage synchronizer. `conv_start` for entry 0 rises after the fourth clock edge that follows the trigger change, counting the first edge that samples the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Mode enable. Low forces idle |
| trig_pol | input | 1 | 1 selects the rising edge, 0 selects the falling edge |
| trig_in | input | 1 | Asynchronous trigger pin |
| ccw_addr | output | 3 | Command table read address |
| ccw_chan | input | 4 | Channel field of the addressed word |
| ccw_pause | input | 1 | Pause bit of the addressed word |
| conv_start | output | 1 | Single-cycle conversion request |
| conv_chan | output | 4 | Channel of the requested conversion |
| conv_done | input | 1 | Converter completion strobe |
| flag_clr | input | 3 | Write-one-to-clear for the completion, pause and overrun flags |
| cmp_flag | output | 1 | Queue completed (sticky) |
| pause_flag | output | 1 | Queue paused (sticky) |
| ovr_flag | output | 1 | Trigger overrun (sticky) |
| ccw_ptr | output | 3 | Current word pointer |
| busy | output | 1 | A word is being issued or converted |

## Verification
The assertions take two things for granted about the converter: it returns exactly one `conv_done` per `conv_start`, and never in the same cycle as the request. They also assume the command table is stable while its address is held. The bench converter model counts a fixed latency from each observed request and fires one strobe. The bench table changes only while the queue is idle. Trigger pulses stay at each level for several clocks, so the synchronizer sees every change.

// File: rtl/tqs_pkg.sv
`timescale 1ns/1ps
// Shared types for the conversion queue sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package tqs_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_PAUSED = 2'd3
    } seq_state_t;

    // Positions of the sticky flags in the set and clear vectors
    localparam int FLG_CMP = 0;
    localparam int FLG_PSE = 1;
    localparam int FLG_OVR = 2;
    localparam int FLG_N   = 3;

endpackage

// File: rtl/tqs_trig_sync.sv
`timescale 1ns/1ps
// Trigger conditioner: it brings the pin into the clock domain and reports a
// single-cycle qualifying edge of the selected direction.
// Assumes: trig_pol is quasi-static. Edges are suppressed until the
// synchronizer holds valid samples after reset.
module tqs_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_pol,
    input  logic trig_in,
    output logic trig_edge
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic [STAGES:0]   primed;

    // First synchronizer stage samples the pin
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= trig_in;
    end

    // Remaining synchronizer stages
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    // Previous synchronized level and the valid-sample shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev   <= 1'b0;
            primed <= '0;
        end else begin
            prev   <= chain[STAGES-1];
            primed <= {primed[STAGES-1:0], 1'b1};
        end
    end

    logic rise, fall;
    // Edge decode on the synchronized level
    always_comb begin
        rise      = chain[STAGES-1] & ~prev;
        fall      = ~chain[STAGES-1] & prev;
        trig_edge = primed[STAGES] & (trig_pol ? rise : fall);
    end

endmodule

// File: rtl/tqs_flags.sv
`timescale 1ns/1ps
// Sticky status flags with write-one-to-clear. A set request wins over a
// clear in the same cycle.
// Assumes: set pulses come from the sequencer, clear bits from the user.
module tqs_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold, set or clear one flag
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= set[i] | (flag_q[i] & ~clr[i]);
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr[i]) |=> flag_q[i]); // R7
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flag_q[i]); // R7
    end

endmodule

// File: rtl/tqs_ccw_ctrl.sv
`timescale 1ns/1ps
// Queue walker: it issues one conversion per command word, waits for done,
// and handles the end-of-queue, pause, overrun and disable cases.
// Assumes: the command table reads asynchronously at ptr. One conv_done
// per conv_start, never in the cycle of the request.
module tqs_ccw_ctrl
    import tqs_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              trig_edge,
    input  logic [CH_W-1:0]   ccw_chan,
    input  logic              ccw_pause,
    input  logic              conv_done,
    output logic [ADDR_W-1:0] ptr,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    output logic              busy,
    output logic [FLG_N-1:0]  flag_set
);
    localparam logic [CH_W-1:0]   EOQ_CODE = {CH_W{1'b1}};
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

    seq_state_t        state;
    logic              pause_q;
    logic              start_q;
    logic [CH_W-1:0]   chan_q;
    logic              is_eoq;
    logic              at_last;

    // Decode of the current word and position
    always_comb begin
        is_eoq  = (ccw_chan == EOQ_CODE);
        at_last = (ptr == LAST_IDX);
        busy    = (state == ST_ISSUE) || (state == ST_WAIT);
    end

    // Flag set requests for this cycle
    always_comb begin
        flag_set          = '0;
        flag_set[FLG_OVR] = enable && trig_edge && busy;
        if (enable) begin
            if (state == ST_ISSUE && is_eoq)
                flag_set[FLG_CMP] = 1'b1;
            if (state == ST_WAIT && conv_done) begin
                if (at_last)      flag_set[FLG_CMP] = 1'b1;
                else if (pause_q) flag_set[FLG_PSE] = 1'b1;
            end
        end
    end

    // Sequencer state, pointer and the conversion request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ptr     <= '0;
            pause_q <= 1'b0;
            start_q <= 1'b0;
            chan_q  <= '0;
        end else if (!enable) begin
            state   <= ST_IDLE;
            ptr     <= '0;
            pause_q <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (trig_edge) state <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (is_eoq) begin
                        ptr   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        start_q <= 1'b1;
                        chan_q  <= ccw_chan;
                        pause_q <= ccw_pause;
                        state   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (conv_done) begin
                        if (at_last) begin
                            ptr   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            ptr   <= ptr + 1'b1;
                            state <= pause_q ? ST_PAUSED : ST_ISSUE;
                        end
                    end
                end
                ST_PAUSED: begin
                    if (trig_edge) state <= ST_ISSUE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign conv_start = start_q;
    assign conv_chan  = chan_q;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R2
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (ptr == '0 && !busy && !conv_start)); // R8
    AST_EOQ_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_ISSUE && is_eoq) |=> !conv_start); // R4
    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_PAUSED && !trig_edge) |=> $stable(ptr)); // R5
    AST_OVR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_WAIT && trig_edge && !conv_done) |=> (state == ST_WAIT)); // R6

endmodule

// File: rtl/trig_queue_seq.sv
`timescale 1ns/1ps
// Top of the edge-triggered conversion queue sequencer. It joins the
// trigger conditioner, the queue walker and the sticky flags.
// Assumes: the command table is an asynchronous read port addressed by
// ccw_addr, and the converter answers each start with one done strobe.
module trig_queue_seq
    import tqs_pkg::*;
#(
    parameter int CH_W        = 4,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              trig_pol,
    input  logic              trig_in,
    output logic [ADDR_W-1:0] ccw_addr,
    input  logic [CH_W-1:0]   ccw_chan,
    input  logic              ccw_pause,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [FLG_N-1:0]  flag_clr,
    output logic              cmp_flag,
    output logic              pause_flag,
    output logic              ovr_flag,
    output logic [ADDR_W-1:0] ccw_ptr,
    output logic              busy
);
    logic              trig_edge;
    logic [ADDR_W-1:0] ptr;
    logic [FLG_N-1:0]  flag_set;
    logic [FLG_N-1:0]  flag_q;

    tqs_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_pol  (trig_pol),
        .trig_in   (trig_in),
        .trig_edge (trig_edge)
    );

    tqs_ccw_ctrl #(.CH_W(CH_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .trig_edge  (trig_edge),
        .ccw_chan   (ccw_chan),
        .ccw_pause  (ccw_pause),
        .conv_done  (conv_done),
        .ptr        (ptr),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .busy       (busy),
        .flag_set   (flag_set)
    );

    tqs_flags #(.N(FLG_N)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (flag_set),
        .clr    (flag_clr),
        .flag_q (flag_q)
    );

    assign ccw_addr   = ptr;
    assign ccw_ptr    = ptr;
    assign cmp_flag   = flag_q[FLG_CMP];
    assign pause_flag = flag_q[FLG_PSE];
    assign ovr_flag   = flag_q[FLG_OVR];

endmodule

// File: tb/trig_queue_seq_test.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps end-of-queue and pause positions under both
// trigger polarities against a behavioural table walk.
module trig_queue_seq_test;
    localparam int EOQ = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       trig_pol = 1'b1;
    logic       trig_in = 1'b0;
    logic [2:0] ccw_addr;
    logic [3:0] ccw_chan;
    logic       ccw_pause;
    logic       conv_start;
    logic [3:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [2:0] flag_clr = 3'b000;
    logic       cmp_flag, pause_flag, ovr_flag, busy;
    logic [2:0] ccw_ptr;

    logic [3:0] tbl_chan [8];
    logic       tbl_pse  [8];
    logic [3:0] log_ch   [32];
    int         log_n = 0;
    int         conv_cnt = 0;
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    logic       idle_lvl = 1'b0;

    always #2.5 clk = ~clk;

    assign ccw_chan  = tbl_chan[ccw_addr];
    assign ccw_pause = tbl_pse[ccw_addr];

    trig_queue_seq uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trig_pol(trig_pol),
        .trig_in(trig_in), .ccw_addr(ccw_addr), .ccw_chan(ccw_chan),
        .ccw_pause(ccw_pause), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .flag_clr(flag_clr), .cmp_flag(cmp_flag),
        .pause_flag(pause_flag), .ovr_flag(ovr_flag), .ccw_ptr(ccw_ptr),
        .busy(busy)
    );

    // Converter model and request log
    always @(negedge clk) begin
        conv_done <= 1'b0;
        if (conv_cnt > 0) begin
            if (conv_cnt == 1) conv_done <= 1'b1;
            conv_cnt <= conv_cnt - 1;
        end
        if (conv_start) begin
            conv_cnt <= 3;
            if (log_n < 32) log_ch[log_n] = conv_chan;
            log_n = log_n + 1;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags(input logic [2:0] m);
        flag_clr = m;
        ticks(1);
        flag_clr = 3'b000;
        ticks(1);
    endtask

    task automatic pulse_trig();
        trig_in = ~idle_lvl;
        ticks(4);
        trig_in = idle_lvl;
        ticks(2);
    endtask

    task automatic load_table(input int seed);
        for (int i = 0; i < 8; i++) begin
            tbl_chan[i] = 4'((i * 5 + seed + 1) % 15);
            tbl_pse[i]  = 1'b0;
        end
    endtask

    // One trigger, then compare against a behavioural walk from start
    task automatic run_segment(input int start, input string tag, output bit done);
        int idx, cnt, endp;
        bit cmp, pse;
        logic [3:0] exp_ch [8];
        idx = start; cnt = 0; cmp = 0; pse = 0;
        while (1) begin
            if (tbl_chan[idx] == 4'(EOQ)) begin cmp = 1; break; end
            exp_ch[cnt] = tbl_chan[idx];
            cnt++;
            if (idx == 7) begin cmp = 1; break; end
            if (tbl_pse[idx]) begin pse = 1; idx++; break; end
            idx++;
        end
        endp = cmp ? 0 : idx;
        log_n = 0;
        pulse_trig();
        ticks(120);
        chk({tag, " R2 count"}, log_n, cnt);
        for (int i = 0; i < cnt; i++)
            chk({tag, " R2 channel order"}, int'(log_ch[i]), int'(exp_ch[i]));
        chk({tag, " R4 cmp_flag"}, int'(cmp_flag), int'(cmp));
        chk({tag, " R5 pause_flag"}, int'(pause_flag), int'(pse));
        chk({tag, " R4 R5 ccw_ptr"}, int'(ccw_ptr), endp);
        clear_flags(3'b111);
        done = cmp;
    endtask

    task automatic setup_pol(input logic pol);
        enable   = 1'b0;
        trig_pol = pol;
        idle_lvl = ~pol;
        trig_in  = ~pol;
        ticks(6);
        enable = 1'b1;
        clear_flags(3'b111);
    endtask

    initial begin
        bit done;
        int s, saved;
        load_table(0);
        ticks(4);
        rst_n = 1'b1;
        ticks(1);
        chk("R8 reset ptr", int'(ccw_ptr), 0);
        chk("R7 reset flags", int'({cmp_flag, pause_flag, ovr_flag}), 0);
        chk("R2 reset start", int'(conv_start), 0);

        for (int pol = 0; pol < 2; pol++) begin
            setup_pol(1'(pol));
            load_table(pol);

            // R9 latency and R2 full queue
            log_n = 0;
            trig_in = ~idle_lvl;
            ticks(3);
            chk("R9 no start before fourth edge", int'(conv_start), 0);
            ticks(1);
            chk("R9 start after fourth edge", int'(conv_start), 1);
            ticks(2);
            trig_in = idle_lvl;
            ticks(120);
            chk("R2 full queue count", log_n, 8);
            chk("R4 full queue cmp", int'(cmp_flag), 1);
            clear_flags(3'b111);

            // R3 restart after completion
            run_segment(0, "R3 restart", done);

            // R1 inactive edge only
            enable = 1'b0;
            trig_in = ~idle_lvl;
            ticks(6);
            enable = 1'b1;
            ticks(6);
            log_n = 0;
            trig_in = idle_lvl;
            ticks(30);
            chk("R1 inactive edge starts nothing", log_n, 0);
            chk("R1 inactive edge busy", int'(busy), 0);

            // R4 end-of-queue code sweep
            for (int e = 0; e < 8; e++) begin
                load_table(pol);
                tbl_chan[e] = 4'(EOQ);
                run_segment(0, "R4 eoq sweep", done);
            end

            // R5 pause position sweep
            for (int p = 0; p < 8; p++) begin
                load_table(pol + p);
                tbl_pse[p] = 1'b1;
                s = 0;
                done = 0;
                for (int k = 0; k < 3 && !done; k++) begin
                    run_segment(s, "R5 pause sweep", done);
                    s = p + 1;
                end
                chk("R5 pause sweep completes", int'(done), 1);
            end

            // R6 overrun and R7 selective clear
            load_table(pol);
            log_n = 0;
            pulse_trig();
            ticks(6);
            pulse_trig();
            ticks(120);
            chk("R6 overrun flag", int'(ovr_flag), 1);
            chk("R6 overrun sequence length", log_n, 8);
            clear_flags(3'b100);
            chk("R7 clear overrun only", int'(ovr_flag), 0);
            chk("R7 completion kept", int'(cmp_flag), 1);
            clear_flags(3'b001);
            chk("R7 clear completion", int'(cmp_flag), 0);

            // R8 disable mid-queue
            log_n = 0;
            pulse_trig();
            ticks(6);
            enable = 1'b0;
            ticks(2);
            chk("R8 disable ptr", int'(ccw_ptr), 0);
            chk("R8 disable busy", int'(busy), 0);
            saved = log_n;
            ticks(40);
            chk("R8 no starts while disabled", log_n, saved);
            enable = 1'b1;
            ticks(2);
            run_segment(0, "R8 after re-enable", done);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule